// File: doc/BRIEF.md
# Machine State Register Update Unit

This block holds a processor's 64-bit machine state register and applies the rules that govern a software write to it. A write value is filtered: bits the implementation does not support are dropped, the hypervisor bit is protected unless the write is both allowed to change it and the processor is already in hypervisor mode, and, on cores with 64-bit segment support, entering problem state forces interrupts and both relocation sides on.

Each committed write can raise side-effect strobes toward neighbouring logic. A translation-change pulse tells the fetch and translation logic that cached translations are stale. A swap pulse tells the register file to exchange registers 0 to 3 with their shadow copies. The block also continuously derives an exception-vector prefix, a halt request, a mode-flags vector, and two 3-bit translation-context indices (instruction side and data side) whose encoding depends on whether the core uses the embedded or the server translation model.

Top module: `msr_update_unit`

## Requirements
- R1: On a write, every bit that is 0 in the parameter WRITE_MASK (default: bit 7 and bits 48 to 55) is committed as 0.
- R2: The hypervisor bit (bit 60) keeps its previous value unless hv_alter_ok is 1 and the held bit 60 is already 1.
- R3: xlat_change is high for exactly the one cycle after a write whose filtered value (after R1 and R2, before R6 forcing) differs from the held value in bit 5 (instruction relocate) or bit 4 (data relocate), or, when embedded_mode is 1, in bit 28 (guest state).
- R4: With SHADOW_EN set, shadow_swap is high for exactly the one cycle after a write whose filtered value differs from the held value in bit 17 (shadow select).
- R5: vec_prefix is 32'hFFF00000 while committed bit 6 is 1 and 32'h00000000 while it is 0.
- R6: When seg64_cap is 1 and the filtered value has bit 14 (problem state) set, bits 15 (interrupt enable), 5 and 4 are committed as 1.
- R7: With embedded_mode 0, each index is (bit14 ? 0 : 1) + (side relocate bit ? 0 : 2) + (bit60 ? 4 : 0); the instruction side uses bit 5 and the data side bit 4.
- R8: With embedded_mode 1, each index is (bit14 ? 0 : 1) + (side space bit ? 2 : 0) + (bit28 ? 4 : 0); the instruction side uses bit 2 and the data side bit 1.
- R9: mode_flags equals the committed register ANDed with the bits 63, 60, 31, 25, 14, 13, 10, 9, 5, 4 and 0, ORed with ext_flags; the imprecise floating-exception bits 11 and 8 never pass.
- R10: halt_req is 1 exactly while committed bit 18 (power management) is 1 and irq_pending is 0.
- R11: Synchronous reset loads RESET_VAL (default: only bit 60 set) and clears xlat_change and shadow_swap; indices follow from that value.
- R12: In a cycle without wr_en the register holds and both pulses are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Value software writes |
| hv_alter_ok | input | 1 | Write may change the hypervisor bit |
| embedded_mode | input | 1 | 1 selects the embedded translation model, 0 the server model |
| seg64_cap | input | 1 | Core has 64-bit segment support |
| irq_pending | input | 1 | An interrupt is pending |
| ext_flags | input | 64 | Mode flags coming from outside the register |
| msr_q | output | 64 | Committed register |
| ictx | output | 3 | Instruction-side translation-context index |
| dctx | output | 3 | Data-side translation-context index |
| mode_flags | output | 64 | Mode-flags vector |
| xlat_change | output | 1 | One-cycle translation-change pulse |
| shadow_swap | output | 1 | One-cycle shadow register swap pulse |
| vec_prefix | output | 32 | Exception-vector prefix |
| halt_req | output | 1 | Halt request |

## Verification
The bench goes after the hypervisor protection from both sides: a write that may alter the bit while it is clear must not set it, and a design that only checks hv_alter_ok would wrongly let a guest promote itself. It entering problem state with relocation off, where a design that compares after forcing would miss or invent a translation-change pulse, and guest-state toggles under both models, where a design ignoring the model would pulse in server mode or stay silent in embedded mode. Masked bits, repeated identical writes (which must raise no pulse), halt gating by irq_pending, and the two index encodings are compared every cycle against a behavioural model over directed and random writes, including a reset in mid-run.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int unsigned MSR_W = 64;
    typedef logic [MSR_W-1:0] msr_t;

    // Field positions inside the register
    localparam int unsigned B_LE  = 0;
    localparam int unsigned B_DS  = 1;
    localparam int unsigned B_IS  = 2;
    localparam int unsigned B_DR  = 4;
    localparam int unsigned B_IR  = 5;
    localparam int unsigned B_EP  = 6;
    localparam int unsigned B_FE1 = 8;
    localparam int unsigned B_BE  = 9;
    localparam int unsigned B_SE  = 10;
    localparam int unsigned B_FE0 = 11;
    localparam int unsigned B_FP  = 13;
    localparam int unsigned B_PR  = 14;
    localparam int unsigned B_EE  = 15;
    localparam int unsigned B_TS  = 17;
    localparam int unsigned B_PW  = 18;
    localparam int unsigned B_VEC = 25;
    localparam int unsigned B_GS  = 28;
    localparam int unsigned B_CM  = 31;
    localparam int unsigned B_HV  = 60;
    localparam int unsigned B_SF  = 63;

    function automatic msr_t bit_at(input int unsigned pos);
        return msr_t'(1) << pos;
    endfunction

    // Bits that reach the mode-flags vector; FE0/FE1 deliberately absent
    localparam msr_t MODE_FLAG_MASK =
        bit_at(B_VEC) | bit_at(B_PR) | bit_at(B_FP) | bit_at(B_SE) |
        bit_at(B_BE)  | bit_at(B_LE) | bit_at(B_IR) | bit_at(B_DR) |
        bit_at(B_CM)  | bit_at(B_SF) | bit_at(B_HV);

    localparam msr_t PRIV_FORCE_BITS = bit_at(B_EE) | bit_at(B_IR) | bit_at(B_DR);

    localparam logic [31:0] VEC_PREFIX_HIGH = 32'hFFF0_0000;

    typedef enum logic {
        XM_SERVER   = 1'b0,
        XM_EMBEDDED = 1'b1
    } xlat_model_e;

    typedef struct packed {
        msr_t value;
        logic xlat_chg;
        logic swap_chg;
    } wr_result_t;

endpackage

// File: rtl/msr_write_filter.sv
module msr_write_filter
    import msr_pkg::*;
#(
    parameter msr_t WRITE_MASK = '1,
    parameter bit   SHADOW_EN  = 1'b1
) (
    input  msr_t        cur,
    input  msr_t        wdata,
    input  logic        hv_alter_ok,
    input  logic        seg64_cap,
    input  xlat_model_e model,
    output wr_result_t  res
);

    msr_t masked;
    msr_t protected_v;
    logic hv_may_change;

    assign masked        = wdata & WRITE_MASK;
    assign hv_may_change = hv_alter_ok && cur[B_HV];

    always_comb begin
        protected_v       = masked;
        protected_v[B_HV] = hv_may_change ? masked[B_HV] : cur[B_HV];
    end

    always_comb begin
        res.xlat_chg = (protected_v[B_IR] ^ cur[B_IR]) |
                       (protected_v[B_DR] ^ cur[B_DR]) |
                       ((model == XM_EMBEDDED) && (protected_v[B_GS] ^ cur[B_GS]));
        res.swap_chg = SHADOW_EN && (protected_v[B_TS] ^ cur[B_TS]);
        if (seg64_cap && protected_v[B_PR]) begin
            res.value = protected_v | PRIV_FORCE_BITS;
        end else begin
            res.value = protected_v;
        end
    end

endmodule

// File: rtl/msr_ctx_index.sv
module msr_ctx_index
    import msr_pkg::*;
#(
    parameter bit DATA_SIDE = 1'b0
) (
    input  xlat_model_e model,
    input  logic        pr,
    input  logic        hv,
    input  logic        gs,
    input  logic        ir,
    input  logic        dr,
    input  logic        isp,
    input  logic        dsp,
    output logic [2:0]  idx
);

    logic reloc;
    logic space;

    assign reloc = DATA_SIDE ? dr  : ir;
    assign space = DATA_SIDE ? dsp : isp;

    always_comb begin
        idx[0] = ~pr;
        if (model == XM_EMBEDDED) begin
            idx[1] = space;
            idx[2] = gs;
        end else begin
            idx[1] = ~reloc;
            idx[2] = hv;
        end
    end

endmodule

// File: rtl/msr_update_unit.sv
module msr_update_unit
    import msr_pkg::*;
#(
    parameter msr_t WRITE_MASK = 64'hFF00_FFFF_FFFF_FF7F,
    parameter msr_t RESET_VAL  = 64'h1000_0000_0000_0000,
    parameter bit   SHADOW_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    input  logic        hv_alter_ok,
    input  logic        embedded_mode,
    input  logic        seg64_cap,
    input  logic        irq_pending,
    input  logic [63:0] ext_flags,
    output logic [63:0] msr_q,
    output logic [2:0]  ictx,
    output logic [2:0]  dctx,
    output logic [63:0] mode_flags,
    output logic        xlat_change,
    output logic        shadow_swap,
    output logic [31:0] vec_prefix,
    output logic        halt_req
);

    localparam int unsigned N_SIDES = 2;

    xlat_model_e model;
    wr_result_t  res;
    logic [2:0]  ctx [N_SIDES];

    assign model = embedded_mode ? XM_EMBEDDED : XM_SERVER;

    msr_write_filter #(
        .WRITE_MASK (WRITE_MASK),
        .SHADOW_EN  (SHADOW_EN)
    ) u_filter (
        .cur         (msr_q),
        .wdata       (wr_data),
        .hv_alter_ok (hv_alter_ok),
        .seg64_cap   (seg64_cap),
        .model       (model),
        .res         (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            msr_q       <= RESET_VAL;
            xlat_change <= 1'b0;
            shadow_swap <= 1'b0;
        end else begin
            xlat_change <= wr_en && res.xlat_chg;
            shadow_swap <= wr_en && res.swap_chg;
            if (wr_en) begin
                msr_q <= res.value;
            end
        end
    end

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        msr_ctx_index #(
            .DATA_SIDE (s == 1)
        ) u_ctx (
            .model (model),
            .pr    (msr_q[B_PR]),
            .hv    (msr_q[B_HV]),
            .gs    (msr_q[B_GS]),
            .ir    (msr_q[B_IR]),
            .dr    (msr_q[B_DR]),
            .isp   (msr_q[B_IS]),
            .dsp   (msr_q[B_DS]),
            .idx   (ctx[s])
        );
    end

    assign ictx       = ctx[0];
    assign dctx       = ctx[1];
    assign mode_flags = (msr_q & MODE_FLAG_MASK) | ext_flags;
    assign vec_prefix = msr_q[B_EP] ? VEC_PREFIX_HIGH : 32'h0;
    assign halt_req   = msr_q[B_PW] && !irq_pending;

    // Hypervisor bit protected unless alteration allowed and already set
    assert_hv_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !(hv_alter_ok && msr_q[B_HV])) |=> (msr_q[B_HV] == $past(msr_q[B_HV])));

    // Problem state on 64-bit segment cores forces EE/IR/DR
    assert_priv_force_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && seg64_cap && wr_data[B_PR] && WRITE_MASK[B_PR])
        |=> (msr_q[B_EE] && msr_q[B_IR] && msr_q[B_DR]));

    // Translation pulse only follows a write strobe
    assert_xlat_after_write_R3: assert property (@(posedge clk) disable iff (rst)
        xlat_change |-> $past(wr_en));

    // Swap pulse only when the shadow-select bit actually flipped
    assert_swap_on_toggle_R4: assert property (@(posedge clk) disable iff (rst)
        shadow_swap |-> (msr_q[B_TS] != $past(msr_q[B_TS])));

    // No write: register stable and no pulses
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(msr_q) && !xlat_change && !shadow_swap));

endmodule

// File: tb/test_msr_update_unit.sv
module test_msr_update_unit;

    localparam logic [63:0] WMASK = 64'hFF00_FFFF_FFFF_FF7F;
    localparam logic [63:0] RVAL  = 64'h1000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        hv_alter_ok = 1'b0;
    logic        embedded_mode = 1'b0;
    logic        seg64_cap = 1'b0;
    logic        irq_pending = 1'b0;
    logic [63:0] ext_flags = '0;
    logic [63:0] msr_q;
    logic [2:0]  ictx, dctx;
    logic [63:0] mode_flags;
    logic        xlat_change, shadow_swap;
    logic [31:0] vec_prefix;
    logic        halt_req;

    int tests = 0;
    int fails = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;

    msr_update_unit i_msr_update_unit (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .hv_alter_ok(hv_alter_ok), .embedded_mode(embedded_mode),
        .seg64_cap(seg64_cap), .irq_pending(irq_pending), .ext_flags(ext_flags),
        .msr_q(msr_q), .ictx(ictx), .dctx(dctx), .mode_flags(mode_flags),
        .xlat_change(xlat_change), .shadow_swap(shadow_swap),
        .vec_prefix(vec_prefix), .halt_req(halt_req)
    );

    // Reference model state
    logic [63:0] m_reg;
    logic        m_xlat, m_swap;

    function automatic logic [63:0] bt(input int p);
        return 64'd1 << p;
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_reg  <= RVAL;
            m_xlat <= 1'b0;
            m_swap <= 1'b0;
        end else if (wr_en) begin
            logic [63:0] v;
            v = wr_data & WMASK;
            if (!(hv_alter_ok && m_reg[60])) v[60] = m_reg[60];
            m_xlat <= (v[5] != m_reg[5]) || (v[4] != m_reg[4]) ||
                      (embedded_mode && (v[28] != m_reg[28]));
            m_swap <= (v[17] != m_reg[17]);
            if (seg64_cap && v[14]) v = v | bt(15) | bt(5) | bt(4);
            m_reg <= v;
        end else begin
            m_xlat <= 1'b0;
            m_swap <= 1'b0;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            int ei, ed;
            logic [63:0] fm;
            if (embedded_mode) begin
                ei = (m_reg[14] ? 0 : 1) + (m_reg[2] ? 2 : 0) + (m_reg[28] ? 4 : 0);
                ed = (m_reg[14] ? 0 : 1) + (m_reg[1] ? 2 : 0) + (m_reg[28] ? 4 : 0);
            end else begin
                ei = (m_reg[14] ? 0 : 1) + (m_reg[5] ? 0 : 2) + (m_reg[60] ? 4 : 0);
                ed = (m_reg[14] ? 0 : 1) + (m_reg[4] ? 0 : 2) + (m_reg[60] ? 4 : 0);
            end
            fm = bt(63) | bt(60) | bt(31) | bt(25) | bt(14) | bt(13) |
                 bt(10) | bt(9) | bt(5) | bt(4) | bt(0);
            chk("R1 R2 R6 R11 R12 register", msr_q, m_reg);
            chk("R3 xlat_change", 64'(xlat_change), 64'(m_xlat));
            chk("R4 shadow_swap", 64'(shadow_swap), 64'(m_swap));
            chk("R5 vec_prefix", 64'(vec_prefix), m_reg[6] ? 64'hFFF0_0000 : 64'h0);
            chk(embedded_mode ? "R8 ictx" : "R7 ictx", 64'(ictx), 64'(ei));
            chk(embedded_mode ? "R8 dctx" : "R7 dctx", 64'(dctx), 64'(ed));
            chk("R9 mode_flags", mode_flags, (m_reg & fm) | ext_flags);
            chk("R10 halt_req", 64'(halt_req), 64'(m_reg[18] && !irq_pending));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [63:0] d, input logic hv);
        wr_en = 1'b1;
        wr_data = d;
        hv_alter_ok = hv;
        cyc();
        wr_en = 1'b0;
        cyc();
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;                          // R11 reset state checked above
        cyc();
        wr(64'h0, 1'b0);                     // R2: HV stays set
        wr(64'h0, 1'b1);                     // R2: HV may clear
        wr(bt(60), 1'b1);                    // R2: cannot set from clear
        wr(bt(5) | bt(4), 1'b0);             // R3 pulse, R7 indices
        wr(bt(5) | bt(4), 1'b0);             // R3 no pulse on repeat
        wr(bt(7) | bt(50) | bt(0), 1'b0);    // R1 masked bits
        wr(bt(14), 1'b0);                    // R6 no forcing without cap
        seg64_cap = 1'b1;
        wr(0, 1'b0);
        wr(bt(14), 1'b0);                    // R6 forcing, R3 pre-force compare
        wr(bt(17), 1'b0);                    // R4 swap
        wr(bt(17), 1'b0);                    // R4 no swap
        wr(0, 1'b0);                         // R4 swap back
        wr(bt(6), 1'b0);                     // R5 prefix high
        wr(0, 1'b0);                         // R5 prefix low
        wr(bt(18) | bt(11) | bt(8), 1'b0);   // R10 halt, R9 FE bits excluded
        irq_pending = 1'b1; cyc();           // R10 gated
        irq_pending = 1'b0; cyc();
        wr(bt(28), 1'b0);                    // R3 GS in server: no pulse
        embedded_mode = 1'b1;
        wr(0, 1'b0);                         // R3 GS in embedded: pulse
        wr(bt(2) | bt(28), 1'b0);            // R8 instruction space
        wr(bt(1), 1'b0);                     // R8 data space
        ext_flags = 64'h0000_0F00_0000_0800; cyc();   // R9
        for (int i = 0; i < 300; i++) begin
            embedded_mode = $urandom_range(0, 1);
            seg64_cap     = $urandom_range(0, 1);
            irq_pending   = $urandom_range(0, 1);
            ext_flags     = (i % 5 == 0) ? {$urandom, $urandom} : 64'h0;
            wr_en         = $urandom_range(0, 2) != 0;
            wr_data       = {$urandom, $urandom} & (($urandom_range(0, 1) != 0) ?
                            64'hFFFF_FFFF_FFFF_FFFF : 64'h1004_0000_1006_6077);
            hv_alter_ok   = $urandom_range(0, 1);
            if (i == 150) rst = 1'b1;        // R11 mid-run reset
            if (i == 152) rst = 1'b0;
            cyc();
        end
        wr_en = 1'b0;
        rst = 1'b0;
        repeat (3) cyc();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule